// File: doc/BRIEF.md
# Indexed Remap Shape-Slot Assignment Unit

This block keeps the remap configuration state of a vector issue stage: four 32-bit shape slots and a status group made of five 2-bit operand selectors, a 5-bit enable field and a persistence bit. A compact "set up indexed remap" command is presented with a one-cycle strobe. The block builds one indexed-layout shape word from the command's size, element-width, swap, skip and index-register fields, then decides which slots receive it and how the status group changes.

Two addressing modes exist. In allocation mode (mode bit 0) the whole state is wiped and every set bit of the 5-bit operand mask claims the next slot in turn, wrapping after the fourth slot. In direct mode (mode bit 1) the mask is read as a selector number and a slot number, only that pair changes, and the configuration is marked persistent. Each strobe produces exactly one atomic update, followed by a done pulse.

Top module: `remap_shape_assign`

## Requirements
- R1: After reset all four shape slots, all selectors, the enable field, the persistence bit and done read zero.
- R2: The update for a strobe sampled at clock edge E becomes visible after edge E+1, and done is high for exactly that one cycle; strobes on consecutive cycles are applied in order on consecutive cycles; without a strobe no state output changes.
- R3: In allocation mode every slot, selector and enable bit is cleared before the new values are written, and the persistence bit ends cleared.
- R4: In allocation mode the mask is scanned from bit 0 to bit 4; each set bit k writes the shape word into the next slot (counter starting at 0, incrementing modulo 4), sets selector k (bits 2k+1:2k of the selector port) to that slot and sets enable bit k; selectors with a clear mask bit stay at 0.
- R5: In allocation mode with all five mask bits set, selector 0 and selector 4 both point at slot 0.
- R6: In direct mode mask bits [4:2] give a selector number (0..4) and bits [1:0] a slot number; only that slot is rewritten, only that selector is set to the slot, its enable bit is set and the persistence bit is set; everything else holds (mask 0b01110 selects selector 3 and slot 2).
- R7: In direct mode a selector number of 5, 6 or 7 changes no state, and done still pulses.
- R8: A shape word has bits [31:30]=00, [29:28]=element-width code, [27:24]=0, [23]=skip, [22:21]=0, [20:18]=110 when swap is 0 and 111 when swap is 1, [17:12]=index-register field shifted left by 1 (the register number, field times 4, halved), [11:6]=second dimension minus one, [5:0]=first dimension minus one.
- R9: The size input holds size minus one (sizes 1..32). Normally the first dimension is the size and the second is 1. With swap 1 and skip 0, the second dimension is ceil(MAXVL / size), with MAXVL 0 taken as 1 and the quotient limited to 64, and the two are stored swapped: first-dimension field = quotient minus one, second-dimension field = size minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_mm_i | input | 1 | Mode: 0 allocation, 1 direct |
| cmd_mask_i | input | 5 | Operand mask, or selector/slot code in direct mode |
| cmd_size_m1_i | input | 5 | Dimension size minus one |
| cmd_ew_i | input | 2 | Element-width code |
| cmd_yx_i | input | 1 | Dimension swap |
| cmd_skip_i | input | 1 | Skip bit |
| cmd_reg_i | input | 5 | Index-register field |
| maxvl_i | input | 7 | Maximum vector length used for the derived dimension |
| shapes_o | output | 128 | Shape slots, slot s at bits 32s+31:32s |
| sel_o | output | 10 | Selector k at bits 2k+1:2k |
| en_o | output | 5 | Enable bit per selector |
| persist_o | output | 1 | Persistence bit |
| done_o | output | 1 | Update-applied pulse |

## Verification
Allocation mode is driven with the empty mask, single bits, sparse masks and the full mask, which separates a wrong scan order, a counter that fails to wrap and a missing clear of stale slots. Direct mode is driven with every selector code including the three invalid ones, on top of a state left by earlier commands, so that writes to the wrong slot or selector and a lost persistence bit show up as changes where none should be. Swap, skip, size 1 and 32 and MAXVL 0 and 127 distinguish the plain dimension form from the derived, clamped and swapped one, and back-to-back strobes check that no command is dropped.

// File: rtl/remap_shape_pkg.sv
package remap_shape_pkg;
  localparam int NSLOT   = 4;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int NSEL    = 5;
  localparam int SELN_W  = $clog2(NSEL);
  localparam int SHAPE_W = 32;
  localparam int SIZE_W  = 5;
  localparam int DIM_W   = 6;
  localparam int MAXVL_W = 7;
  localparam int REG_W   = 5;
  localparam int EW_W    = 2;
  localparam int QCLAMP  = 64;

  typedef struct packed {
    logic                mm;
    logic [NSEL-1:0]     mask;
    logic [SIZE_W-1:0]   size_m1;
    logic [EW_W-1:0]     ew;
    logic                yx;
    logic                skip;
    logic [REG_W-1:0]    reg_f;
    logic [MAXVL_W-1:0]  maxvl;
  } cmd_t;
endpackage

// File: rtl/remap_shape_build.sv
module remap_shape_build
  import remap_shape_pkg::*;
(
  input  cmd_t               cmd_i,
  output logic [SHAPE_W-1:0] word_o
);
  localparam int Q_W = MAXVL_W + 1;

  logic [DIM_W-1:0]   size_full;
  logic [MAXVL_W-1:0] mv_eff;
  logic [Q_W-1:0]     numer;
  logic [Q_W-1:0]     quot;
  logic [Q_W-1:0]     quot_m1;
  logic [DIM_W-1:0]   xdim_f;
  logic [DIM_W-1:0]   ydim_f;
  logic               derive;

  always_comb begin
    size_full = {1'b0, cmd_i.size_m1} + DIM_W'(1);
    mv_eff    = (cmd_i.maxvl == '0) ? MAXVL_W'(1) : cmd_i.maxvl;
    numer     = {1'b0, mv_eff} + Q_W'(size_full) - Q_W'(1);
    quot      = numer / Q_W'(size_full);
    if (quot > Q_W'(QCLAMP)) quot = Q_W'(QCLAMP);
    quot_m1   = quot - Q_W'(1);
    derive    = cmd_i.yx && !cmd_i.skip;
    if (derive) begin
      xdim_f = quot_m1[DIM_W-1:0];
      ydim_f = {1'b0, cmd_i.size_m1};
    end else begin
      xdim_f = {1'b0, cmd_i.size_m1};
      ydim_f = '0;
    end
  end

  assign word_o = {2'b00, cmd_i.ew, 4'b0000, cmd_i.skip, 2'b00,
                   2'b11, cmd_i.yx, cmd_i.reg_f, 1'b0, ydim_f, xdim_f};
endmodule

// File: rtl/remap_slot_alloc.sv
module remap_slot_alloc
  import remap_shape_pkg::*;
(
  input  logic [NSEL-1:0]              mask_i,
  output logic [NSEL-1:0][SLOT_W-1:0]  sel_map_o,
  output logic [NSLOT-1:0]             slot_we_o
);
  logic [SLOT_W-1:0] cursor;

  always_comb begin
    cursor    = '0;
    sel_map_o = '0;
    slot_we_o = '0;
    for (int k = 0; k < NSEL; k++) begin
      if (mask_i[k]) begin
        sel_map_o[k]      = cursor;
        slot_we_o[cursor] = 1'b1;
        cursor            = cursor + SLOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/remap_shape_assign.sv
module remap_shape_assign
  import remap_shape_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid_i,
  input  logic                     cmd_mm_i,
  input  logic [4:0]               cmd_mask_i,
  input  logic [4:0]               cmd_size_m1_i,
  input  logic [1:0]               cmd_ew_i,
  input  logic                     cmd_yx_i,
  input  logic                     cmd_skip_i,
  input  logic [4:0]               cmd_reg_i,
  input  logic [6:0]               maxvl_i,
  output logic [127:0]             shapes_o,
  output logic [9:0]               sel_o,
  output logic [4:0]               en_o,
  output logic                     persist_o,
  output logic                     done_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  cmd_t cmd_in, cmd_q;
  logic pend_q, done_q;
  logic [NSLOT-1:0][SHAPE_W-1:0] shape_q, shape_d;
  logic [NSEL-1:0][SLOT_W-1:0]   sel_q, sel_d;
  logic [NSEL-1:0]               en_q, en_d;
  logic                          pers_q, pers_d;

  logic [SHAPE_W-1:0]            word;
  logic [NSEL-1:0][SLOT_W-1:0]   alloc_map;
  logic [NSLOT-1:0]              alloc_we;
  logic [2:0]                    dsel;
  logic [SLOT_W-1:0]             dslot;

  assign cmd_in = '{mm: cmd_mm_i, mask: cmd_mask_i, size_m1: cmd_size_m1_i,
                    ew: cmd_ew_i, yx: cmd_yx_i, skip: cmd_skip_i,
                    reg_f: cmd_reg_i, maxvl: maxvl_i};

  remap_shape_build u_build (.cmd_i(cmd_q), .word_o(word));
  remap_slot_alloc  u_alloc (.mask_i(cmd_q.mask), .sel_map_o(alloc_map), .slot_we_o(alloc_we));

  assign dsel  = cmd_q.mask[4:2];
  assign dslot = cmd_q.mask[1:0];

  // command capture stage
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pend_q <= 1'b0;
      cmd_q  <= '0;
    end else begin
      pend_q <= cmd_valid_i;
      if (cmd_valid_i) cmd_q <= cmd_in;
    end
  end

  // next-state for the remap state
  always_comb begin
    shape_d = shape_q;
    sel_d   = sel_q;
    en_d    = en_q;
    pers_d  = pers_q;
    if (pend_q) begin
      if (!cmd_q.mm) begin
        for (int s = 0; s < NSLOT; s++)
          shape_d[s] = alloc_we[s] ? word : '0;
        sel_d  = alloc_map;
        en_d   = cmd_q.mask;
        pers_d = 1'b0;
      end else if (dsel < 3'(NSEL)) begin
        shape_d[dslot] = word;
        sel_d[dsel]    = dslot;
        en_d[dsel]     = 1'b1;
        pers_d         = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      shape_q <= '0;
      sel_q   <= '0;
      en_q    <= '0;
      pers_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= pend_q;
      if (pend_q) begin
        shape_q <= shape_d;
        sel_q   <= sel_d;
        en_q    <= en_d;
        pers_q  <= pers_d;
      end
    end
  end

  assign shapes_o  = shape_q;
  assign sel_o     = sel_q;
  assign en_o      = en_q;
  assign persist_o = pers_q;
  assign done_o    = done_q;

  // ---------------- assertions ----------------
  assert_done_timing_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    cmd_valid_i |=> ##1 done_o);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !pend_q |=> ($stable(shapes_o) && $stable(sel_o) && $stable(en_o) && $stable(persist_o)));

  assert_persist_clear_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pend_q && !cmd_q.mm) |=> !persist_o);

  assert_full_wrap_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pend_q && !cmd_q.mm && cmd_q.mask == 5'h1f) |=> (sel_o[1:0] == 2'd0 && sel_o[9:8] == 2'd0));

  assert_direct_persist_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pend_q && cmd_q.mm && cmd_q.mask[4:2] < 3'd5) |=> persist_o);

  assert_bad_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pend_q && cmd_q.mm && cmd_q.mask[4:2] > 3'd4) |=>
      ($stable(shapes_o) && $stable(sel_o) && $stable(en_o) && $stable(persist_o)));

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot_chk
    assert_untouched_slot_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
      (pend_q && cmd_q.mm && cmd_q.mask[1:0] != s) |=> $stable(shapes_o[s*SHAPE_W +: SHAPE_W]));
  end
endmodule

// File: tb/remap_shape_assign_bench.sv
module remap_shape_assign_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_mm, cmd_yx, cmd_skip;
  logic [4:0] cmd_mask, cmd_size_m1, cmd_reg;
  logic [1:0] cmd_ew;
  logic [6:0] maxvl;
  logic [127:0] shapes;
  logic [9:0] sel;
  logic [4:0] en;
  logic persist, done;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_shape [4];
  logic [1:0]  m_sel   [5];
  logic [4:0]  m_en;
  logic        m_pers;

  always #(CLK_PERIOD/2) clk = ~clk;

  remap_shape_assign u_remap_shape_assign (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_mm_i(cmd_mm),
    .cmd_mask_i(cmd_mask), .cmd_size_m1_i(cmd_size_m1), .cmd_ew_i(cmd_ew),
    .cmd_yx_i(cmd_yx), .cmd_skip_i(cmd_skip), .cmd_reg_i(cmd_reg), .maxvl_i(maxvl),
    .shapes_o(shapes), .sel_o(sel), .en_o(en), .persist_o(persist), .done_o(done));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8, R9: expected shape word
  function automatic logic [31:0] exp_word(input logic [4:0] sm1, input logic [1:0] ew,
                                           input logic yx, input logic sk,
                                           input logic [4:0] rg, input logic [6:0] mv);
    int sz = int'(sm1) + 1;
    int m = (mv == 0) ? 1 : int'(mv);
    int q = 0;
    int xf, yf;
    while (q * sz < m) q++;
    if (q > 64) q = 64;
    if (yx && !sk) begin xf = q - 1; yf = sz - 1; end
    else begin xf = sz - 1; yf = 0; end
    return {2'b00, ew, 4'h0, sk, 2'b00, 2'b11, yx, rg, 1'b0, 6'(yf), 6'(xf)};
  endfunction

  function automatic logic [127:0] m_shapes();
    return {m_shape[3], m_shape[2], m_shape[1], m_shape[0]};
  endfunction
  function automatic logic [9:0] m_selv();
    return {m_sel[4], m_sel[3], m_sel[2], m_sel[1], m_sel[0]};
  endfunction

  task automatic model_apply(input logic mm, input logic [4:0] mk, input logic [31:0] w);
    if (!mm) begin
      int c = 0;
      for (int s = 0; s < 4; s++) m_shape[s] = '0;
      for (int k = 0; k < 5; k++) m_sel[k] = '0;
      for (int k = 0; k < 5; k++) if (mk[k]) begin
        m_shape[c] = w; m_sel[k] = 2'(c); c = (c + 1) % 4;
      end
      m_en = mk; m_pers = 1'b0;
    end else if (mk[4:2] < 5) begin
      m_shape[mk[1:0]] = w; m_sel[mk[4:2]] = mk[1:0];
      m_en[mk[4:2]] = 1'b1; m_pers = 1'b1;
    end
  endtask

  task automatic check_state(input string req);
    chk(shapes == m_shapes(), {req, " shapes"}, shapes, m_shapes());
    chk(sel == m_selv(), {req, " selectors"}, 128'(sel), 128'(m_selv()));
    chk(en == m_en && persist == m_pers, {req, " enable/persist"},
        128'({en, persist}), 128'({m_en, m_pers}));
  endtask

  task automatic drive(input logic mm, input logic [4:0] mk, input logic [4:0] sm1,
                       input logic [1:0] ew, input logic yx, input logic sk,
                       input logic [4:0] rg, input logic [6:0] mv);
    cmd_valid = 1'b1; cmd_mm = mm; cmd_mask = mk; cmd_size_m1 = sm1;
    cmd_ew = ew; cmd_yx = yx; cmd_skip = sk; cmd_reg = rg; maxvl = mv;
  endtask

  // one command, full timing check (R2)
  task automatic send(input string req, input logic mm, input logic [4:0] mk,
                      input logic [4:0] sm1, input logic [1:0] ew, input logic yx,
                      input logic sk, input logic [4:0] rg, input logic [6:0] mv);
    drive(mm, mk, sm1, ew, yx, sk, rg, mv);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(done == 1'b0, "R2 done early", 128'(done), 128'(0));
    chk(shapes == m_shapes(), "R2 no early update", shapes, m_shapes());
    @(negedge clk);
    model_apply(mm, mk, exp_word(sm1, ew, yx, sk, rg, mv));
    chk(done == 1'b1, "R2 done pulse", 128'(done), 128'(1));
    check_state(req);
    @(negedge clk);
    chk(done == 1'b0, "R2 done single cycle", 128'(done), 128'(0));
    check_state("R2 hold");
  endtask

  task automatic send_rand();
    logic mm = 1'($urandom);
    send(mm ? "R6 random direct" : "R4 random alloc", mm, 5'($urandom), 5'($urandom),
         2'($urandom), 1'($urandom), 1'($urandom), 5'($urandom), 7'($urandom));
  endtask

  initial begin
    int wd = 0;
    while (wd < 200000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", wd);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cmd_valid = 0; cmd_mm = 0; cmd_mask = 0; cmd_size_m1 = 0; cmd_ew = 0;
    cmd_yx = 0; cmd_skip = 0; cmd_reg = 0; maxvl = 0;
    for (int s = 0; s < 4; s++) m_shape[s] = '0;
    for (int k = 0; k < 5; k++) m_sel[k] = '0;
    m_en = '0; m_pers = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 reset");
    chk(done == 1'b0, "R1 done reset", 128'(done), 128'(0));

    // direct mode, example code: selector 3, slot 2 (R6)
    send("R6 direct 0b01110", 1'b1, 5'b01110, 5'd3, 2'd1, 1'b0, 1'b0, 5'd7, 7'd16);
    send("R6 direct sel0 slot1", 1'b1, 5'b00001, 5'd0, 2'd2, 1'b1, 1'b1, 5'd9, 7'd40);
    // invalid selector codes (R7)
    send("R7 bad selector 5", 1'b1, 5'b10100, 5'd5, 2'd3, 1'b0, 1'b0, 5'd1, 7'd9);
    send("R7 bad selector 7", 1'b1, 5'b11111, 5'd5, 2'd3, 1'b1, 1'b0, 5'd1, 7'd9);
    // allocation: full mask wraps (R5), sparse (R4), empty clears (R3)
    send("R5 full mask wrap", 1'b0, 5'b11111, 5'd2, 2'd0, 1'b0, 1'b0, 5'd3, 7'd12);
    chk(sel[1:0] == 2'd0 && sel[9:8] == 2'd0, "R5 sel0/sel4 slot0", 128'(sel), 128'(10'b00_11_10_01_00));
    send("R4 sparse mask", 1'b0, 5'b10101, 5'd4, 2'd1, 1'b0, 1'b1, 5'd31, 7'd20);
    send("R3 empty mask clears", 1'b0, 5'b00000, 5'd4, 2'd1, 1'b0, 0, 5'd0, 7'd20);
    chk(shapes == '0 && en == '0 && !persist, "R3 cleared", shapes, '0);
    // dimension corners (R9, R8)
    send("R9 swap maxvl127 size1 clamp", 1'b1, 5'b00000, 5'd0, 2'd0, 1'b1, 1'b0, 5'd31, 7'd127);
    send("R9 swap maxvl0", 1'b1, 5'b00111, 5'd31, 2'd3, 1'b1, 1'b0, 5'd2, 7'd0);
    send("R9 swap maxvl127 size32", 1'b1, 5'b01010, 5'd31, 2'd2, 1'b1, 1'b0, 5'd4, 7'd127);
    send("R8 swap with skip", 1'b1, 5'b10011, 5'd6, 2'd1, 1'b1, 1'b1, 5'd16, 7'd50);
    send("R3 persist cleared after direct", 1'b0, 5'b00110, 5'd1, 2'd0, 1'b0, 1'b0, 5'd5, 7'd8);

    // back-to-back strobes (R2)
    drive(1'b1, 5'b00010, 5'd7, 2'd2, 1'b1, 1'b0, 5'd11, 7'd33);
    @(negedge clk);
    drive(1'b0, 5'b01001, 5'd3, 2'd1, 1'b0, 1'b0, 5'd6, 7'd33);
    @(negedge clk);
    cmd_valid = 1'b0;
    model_apply(1'b1, 5'b00010, exp_word(5'd7, 2'd2, 1'b1, 1'b0, 5'd11, 7'd33));
    check_state("R2 back-to-back first");
    @(negedge clk);
    model_apply(1'b0, 5'b01001, exp_word(5'd3, 2'd1, 1'b0, 1'b0, 5'd6, 7'd33));
    chk(done == 1'b1, "R2 second done", 128'(done), 128'(1));
    check_state("R2 back-to-back second");
    @(negedge clk);

    for (int n = 0; n < 300; n++) send_rand();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule